// File: doc/BRIEF.md
# Synchronized Channel Start Controller

This block holds each channel of a four-channel processing device asleep after a hard reset and releases it in one of three ways. Software can clear a channel's sleep bit directly. Software can issue a start command that addresses one or more channels and starts each one's hold-off countdown. A channel can also be armed to start its countdown when a chosen external sync pin is seen high. The countdown length is set per channel by a 16-bit hold-off value. This lets several channels, or several devices that share a sync pin, leave sleep on the same clock edge.

A single write port reaches all control state. Address bits [3:2] select the channel and bits [1:0] select the register: 0 is the mode register, 1 is the hold-off value, 2 is the pin configuration, and 3 is the shared start command. Each channel runs a small state machine with three states. In `ST_ASLEEP` the channel is waiting. In `ST_HOLDOFF` it is counting down. In `ST_ACTIVE` it has been released. The transitions are:
- *direct wake*: ASLEEP or HOLDOFF to ACTIVE, on a mode write with sleep low.
- *trigger*: ASLEEP to HOLDOFF, or straight to ACTIVE when the hold-off is 0 or 1.
- *restart*: HOLDOFF to HOLDOFF, when a new soft trigger arrives.
- *expiry*: HOLDOFF to ACTIVE.
- *put to sleep*: ACTIVE or HOLDOFF to ASLEEP, on a mode write with sleep high.

Top module: `chan_start_ctrl`

## Requirements
- R1: After reset every `sleep` bit is 1 and every `prog` bit is 0.
- R2: A write to register 0 of a channel with bit 0 = 0 drives that channel's `sleep` low from the write edge on. A write with bit 0 = 1 drives it high and abandons any countdown in progress.
- R3: Bit 1 of register 0 sets the channel's `prog` output. `prog` changes only on such writes, and it has no effect on starting.
- R4: A write to register 3 with bit 4 (start) = 1 triggers every sleeping channel whose bit in [3:0] is set. Channels whose bit is clear are unaffected. A register 3 write with bit 4 = 0 has no effect. The start bit is a strobe and is never stored.
- R5: With hold-off H ≥ 2 (register 1), `sleep` falls H-1 edges after the trigger edge, which is the moment the count reaches one. With H of 0 or 1, `sleep` falls on the trigger edge itself.
- R6: Register 2 holds a pin enable mask in [3:0] and an arm bit at bit 4. An armed sleeping channel triggers when an enabled pin is high. The pin passes through two sampling flops, so the trigger edge is two edges after the first edge that samples the pin high, and `sleep` falls H+1 edges after that first sampling edge.
- R7: Sync pins have no effect on a channel that is counting down or active, that is not armed, or whose mask does not enable the pin that is high.
- R8: A soft trigger that arrives during a countdown restarts the countdown from the current hold-off value.
- R9: Soft triggers addressed to an active channel leave it active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Channel in [3:2], register in [1:0] |
| wr_data | input | 16 | Write data |
| sync_pin | input | 4 | External sync pins, asynchronous |
| sleep | output | 4 | Per-channel sleep state |
| prog | output | 4 | Per-channel program-mode state |

## Verification
The assertions assume that at most one register write happens per clock, so a mode write and a start command never land on the same edge, and that a hold-off value is not rewritten in the cycle it is being loaded. The bench issues every write through one task that holds `wr_en` for exactly one edge, and it keeps hold-off writes ahead of any trigger. Random hold-off values and channel masks stay below 25, so every countdown ends inside the bench's observation window. Sync pins change only at falling clock edges.

// File: rtl/chan_start_pkg.sv
package chan_start_pkg;

    typedef enum logic [1:0] {
        ST_ASLEEP  = 2'd0,
        ST_HOLDOFF = 2'd1,
        ST_ACTIVE  = 2'd2
    } chan_state_e;

    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_HOLD = 2'd1;
    localparam logic [1:0] REG_PCFG = 2'd2;
    localparam logic [1:0] REG_CMD  = 2'd3;

    localparam int SLEEP_BIT = 0;
    localparam int PROG_BIT  = 1;

endpackage

// File: rtl/sync_pin_cdc.sv
module sync_pin_cdc #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic stage1_q, stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= pin_async[p];
                stage2_q <= stage1_q;
            end
        end
        assign pin_sync[p] = stage2_q;
    end
endmodule

// File: rtl/chan_reg_decode.sv
module chan_reg_decode
    import chan_start_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int ADDR_W = CH_W + 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_CH:0]   cmd_bits,
    output logic [NUM_CH-1:0] mode_we,
    output logic [NUM_CH-1:0] hold_we,
    output logic [NUM_CH-1:0] pcfg_we,
    output logic [NUM_CH-1:0] soft_trig
);
    logic [CH_W-1:0] ch_sel;
    logic [1:0]      reg_sel;
    logic            cmd_start;

    assign ch_sel    = wr_addr[ADDR_W-1:2];
    assign reg_sel   = wr_addr[1:0];
    assign cmd_start = wr_en && (reg_sel == REG_CMD) && cmd_bits[NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit          = wr_en && (ch_sel == CH_W'(c));
        assign mode_we[c]   = hit && (reg_sel == REG_MODE);
        assign hold_we[c]   = hit && (reg_sel == REG_HOLD);
        assign pcfg_we[c]   = hit && (reg_sel == REG_PCFG);
        assign soft_trig[c] = cmd_start && cmd_bits[c];
    end
endmodule

// File: rtl/chan_start_fsm.sv
module chan_start_fsm
    import chan_start_pkg::*;
#(
    parameter int HOLD_W   = 16,
    parameter int NUM_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              hold_we,
    input  logic              pcfg_we,
    input  logic              soft_trig,
    input  logic [HOLD_W-1:0] wr_data,
    input  logic [NUM_PINS-1:0] pin_lvl,
    output logic              sleep_o,
    output logic              prog_o
);
    localparam logic [HOLD_W-1:0] TWO = HOLD_W'(2);

    chan_state_e         state_q, state_d;
    logic [HOLD_W-1:0]   cnt_q, cnt_d;
    logic [HOLD_W-1:0]   hold_q;
    logic [NUM_PINS-1:0] pin_mask_q;
    logic                pin_arm_q;
    logic                prog_q;
    logic                pin_hit;
    logic                short_hold;

    assign pin_hit    = pin_arm_q && |(pin_mask_q & pin_lvl);
    assign short_hold = hold_q < TWO;

    // configuration registers, writable in every state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            pin_mask_q <= '0;
            pin_arm_q  <= 1'b0;
            prog_q     <= 1'b0;
        end else begin
            if (hold_we) hold_q <= wr_data;
            if (pcfg_we) begin
                pin_mask_q <= wr_data[NUM_PINS-1:0];
                pin_arm_q  <= wr_data[NUM_PINS];
            end
            if (mode_we) prog_q <= wr_data[PROG_BIT];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ASLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ASLEEP: begin
                if (mode_we) begin
                    if (!wr_data[SLEEP_BIT]) state_d = ST_ACTIVE;
                end else if (soft_trig || pin_hit) begin
                    if (short_hold) state_d = ST_ACTIVE;
                    else begin
                        state_d = ST_HOLDOFF;
                        cnt_d   = hold_q;
                    end
                end
            end
            ST_HOLDOFF: begin
                if (mode_we) begin
                    state_d = wr_data[SLEEP_BIT] ? ST_ASLEEP : ST_ACTIVE;
                end else if (soft_trig) begin
                    if (short_hold) state_d = ST_ACTIVE;
                    else cnt_d = hold_q;
                end else if (cnt_q <= TWO) begin
                    state_d = ST_ACTIVE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (mode_we && wr_data[SLEEP_BIT]) state_d = ST_ASLEEP;
            end
            default: state_d = ST_ASLEEP;
        endcase
    end

    // outputs
    always_comb begin
        sleep_o = (state_q != ST_ACTIVE);
        prog_o  = prog_q;
    end

    assert_reset_asleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sleep_o);
    assert_mode_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !wr_data[SLEEP_BIT]) |=> !sleep_o);
    assert_mode_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && wr_data[SLEEP_BIT]) |=> (sleep_o && state_q == ST_ASLEEP));
    assert_prog_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(prog_o));
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF && !mode_we && !soft_trig && cnt_q > TWO)
        |=> (state_q == ST_HOLDOFF && cnt_q == $past(cnt_q) - 1'b1));
    assert_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF && !mode_we && !soft_trig && cnt_q <= TWO) |=> !sleep_o);
    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && !mode_we && !soft_trig && !pin_hit)
        |=> (sleep_o && state_q == ST_ASLEEP));
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF && soft_trig && !mode_we && !short_hold)
        |=> (cnt_q == $past(hold_q)));
    assert_active_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !mode_we) |=> !sleep_o);
endmodule

// File: rtl/chan_start_ctrl.sv
module chan_start_ctrl
    import chan_start_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PINS = 4,
    parameter int HOLD_W   = 16,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int ADDR_W   = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HOLD_W-1:0] wr_data,
    input  logic [NUM_PINS-1:0] sync_pin,
    output logic [NUM_CH-1:0] sleep,
    output logic [NUM_CH-1:0] prog
);
    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_CH-1:0]   mode_we, hold_we, pcfg_we, soft_trig;

    sync_pin_cdc #(.NUM_PINS(NUM_PINS)) u_cdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sync_pin),
        .pin_sync  (pin_lvl)
    );

    chan_reg_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .cmd_bits  (wr_data[NUM_CH:0]),
        .mode_we   (mode_we),
        .hold_we   (hold_we),
        .pcfg_we   (pcfg_we),
        .soft_trig (soft_trig)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        chan_start_fsm #(.HOLD_W(HOLD_W), .NUM_PINS(NUM_PINS)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_we   (mode_we[c]),
            .hold_we   (hold_we[c]),
            .pcfg_we   (pcfg_we[c]),
            .soft_trig (soft_trig[c]),
            .wr_data   (wr_data),
            .pin_lvl   (pin_lvl),
            .sleep_o   (sleep[c]),
            .prog_o    (prog[c])
        );
    end

    assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_we | hold_we | pcfg_we));
endmodule

// File: tb/chan_start_ctrl_test.sv
module chan_start_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  sync_pin = '0;
    logic [3:0]  sleep, prog;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    localparam int NEVER = 32'h7fffffff;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chan_start_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_pin(sync_pin), .sleep(sleep), .prog(prog)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ad(int ch, int rg);
        return {2'(ch), 2'(rg)};
    endfunction

    // expected release edge for a trigger on edge trig with hold-off h
    function automatic int wake_at(int trig, int h);
        return (h <= 1) ? trig : trig + h - 1;
    endfunction

    task automatic wr(logic [3:0] a, logic [15:0] d, output int edge_no);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        edge_no = cyc;
        wr_en = 1'b0;
    endtask

    task automatic watch(int n, int wk[4], string req);
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++)
                chk(req, 32'(sleep[c]), 32'(cyc < wk[c]));
        end
    endtask

    task automatic all_sleep();
        int e;
        for (int c = 0; c < 4; c++) wr(ad(c, 0), 16'h0001, e);
    endtask

    initial begin
        int e, e2, n;
        int wk[4];
        int hv[4];
        logic [3:0] msk;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        chk("R1 sleep", 32'(sleep), 32'hF);
        chk("R1 prog", 32'(prog), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sleep after release", 32'(sleep), 32'hF);

        // R2 direct wake and sleep, R3 prog bit
        wr(ad(1, 0), 16'h0000, e);
        @(negedge clk);
        chk("R2 direct wake", 32'(sleep), 32'hD);
        wr(ad(1, 0), 16'h0003, e);
        @(negedge clk);
        chk("R2 back to sleep", 32'(sleep), 32'hF);
        chk("R3 prog set", 32'(prog), 32'h2);
        wr(ad(1, 0), 16'h0001, e);
        @(negedge clk);
        chk("R3 prog clear", 32'(prog), 32'h0);

        // R4 command without start bit does nothing
        wr(ad(0, 1), 16'd5, e);
        wr(ad(1, 1), 16'd9, e);
        wr(ad(2, 1), 16'd0, e);
        wr(ad(3, 1), 16'd2, e);
        wr(ad(0, 3), 16'h000F, e);
        wk = '{NEVER, NEVER, NEVER, NEVER};
        watch(4, wk, "R4 no start bit");

        // R4/R5 soft start of channels 0,2,3
        wr(ad(0, 3), 16'h001D, e);
        wk = '{wake_at(e, 5), NEVER, wake_at(e, 0), wake_at(e, 2)};
        #1;
        for (int c = 0; c < 4; c++) chk("R5 trigger edge", 32'(sleep[c]), 32'(e < wk[c]));
        watch(8, wk, "R5 soft countdown");

        // R9 active channels ignore triggers, channel 1 counts
        wr(ad(0, 3), 16'h001F, e);
        wk = '{0, wake_at(e, 9), 0, 0};
        watch(11, wk, "R9 active ignores start");

        // R8 restart during countdown
        all_sleep();
        wr(ad(0, 1), 16'd12, e);
        wr(ad(0, 3), 16'h0011, e);
        wk = '{NEVER, NEVER, NEVER, NEVER};
        watch(5, wk, "R8 counting");
        wr(ad(0, 3), 16'h0011, e2);
        wk = '{wake_at(e2, 12), NEVER, NEVER, NEVER};
        watch(14, wk, "R8 restarted");

        // R6/R7 pin start
        all_sleep();
        wr(ad(2, 1), 16'd6, e);
        wr(ad(0, 1), 16'd3, e);
        wr(ad(2, 2), 16'h0012, e);
        wr(ad(0, 2), 16'h0011, e);
        wr(ad(1, 2), 16'h0002, e);
        wr(ad(3, 2), 16'h0010, e);
        @(negedge clk);
        sync_pin = 4'b0010;
        n = cyc;
        wk = '{NEVER, NEVER, n + 1 + 6 + 1, NEVER};
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++)
                chk("R6 pin start / R7 unarmed or masked", 32'(sleep[c]), 32'(cyc < wk[c]));
            if (i == 2) sync_pin = 4'b0000;
            if (i == 4) sync_pin = 4'b0010;
        end
        @(negedge clk);
        sync_pin = 4'b0011;
        n = cyc;
        wk = '{n + 1 + 3 + 1, NEVER, 0, NEVER};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++)
                chk("R6 pin0 / R7 pin on active ignored", 32'(sleep[c]), 32'(cyc < wk[c]));
        end
        sync_pin = 4'b0000;

        // random soft starts
        for (int it = 0; it < 20; it++) begin
            all_sleep();
            for (int c = 0; c < 4; c++) begin
                hv[c] = int'($urandom_range(0, 24));
                wr(ad(c, 1), 16'(hv[c]), e);
            end
            msk = 4'($urandom_range(0, 15));
            wr(ad(2, 3), {11'd0, 1'b1, msk}, e);
            for (int c = 0; c < 4; c++) wk[c] = msk[c] ? wake_at(e, hv[c]) : NEVER;
            watch(27, wk, "R4 R5 random start");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule